// File: doc/BRIEF.md
# DMA Block Length Reload Counter

This unit keeps track of how many transfer units are left in the current block or repeat run of one DMA channel. It has one 32-bit register. The upper half is the programmed block length. The lower half is the live remaining count. Every transfer strobe that arrives while the channel is active, and while the channel is in a repeat or block mode, takes one off the count. When the count runs out, it refills from the length half, and a one-cycle block-end pulse goes out to the rest of the channel logic.

Software writes the whole register while the channel is idle, putting the same value in both halves. A length of zero stands for the largest block, 65536 units. While the channel runs, the length half is protected against writes, but the live count can still be rewritten. In normal mode the unit ignores strobes. It counts abstract units only; the size of each unit is decided elsewhere.

Top module: `blk_len_counter`

## Requirements
- R1: After synchronous reset, both halves of the register read as zero and `blk_end` is low.
- R2: `reg_rdata` always shows the length in bits 31:16 and the live count in bits 15:0. A write with `reg_wr` high is visible there on the cycle after the clock edge that takes it.
- R3: A counting strobe decrements a count greater than 1 by one. A counting strobe is `xfer_stb` high while `chan_act` is high and `xfer_mode` is 2'b01 (repeat) or 2'b10 (block).
- R4: A counting strobe on a count of 1 reloads the count from the length half. The same edge raises `blk_end` for exactly one cycle.
- R5: A write to the length half (bits 31:16) takes effect only while `chan_act` is low. While the channel is active, the length half keeps its value.
- R6: A counting strobe on a count of 0 treats it as 65536. The count becomes 65535 and no `blk_end` pulse is given.
- R7: Strobes have no effect in mode 2'b00 (normal), in mode 2'b11, or while `chan_act` is low.
- R8: When a write and a counting strobe arrive in the same cycle, the strobe decides the count half.
- R9: A length of zero gives a block of 65536 counting strobes between `blk_end` pulses.
- R10: The count half can be written at any time, active or idle, when no counting strobe is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_mode | input | 2 | Transfer mode: 00 normal, 01 repeat, 10 block, 11 treated as normal |
| chan_act | input | 1 | Channel is running |
| xfer_stb | input | 1 | One transfer unit completed |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Write data: length in 31:16, count in 15:0 |
| reg_rdata | output | 32 | Read data: length and live count |
| blk_end | output | 1 | One-cycle pulse when a block completes |

## Verification
The bench goes after these corner cases:
- **The 1-to-reload step.** A design that lets the count reach zero and reloads it one strobe later would lengthen every block by one unit and move `blk_end` one strobe late.
- **Zero at a strobe.** A design that reloaded from zero, or fired the pulse there, would cut a maximum block short.
- **A full block of zero length.** This covers all 65536 strobes, so a pulse at the wrong place in the wrap shows up.
- **Register protection and priority.** Length writes during activity must be dropped, and a write in the same cycle as a strobe must lose on the count half. A design that lets the length change mid-run would corrupt the next reload. One that lets the write win would lose a unit.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/dbs_step_gate.sv
module dbs_step_gate
  import dbs_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       act_i,
  input  logic       stb_i,
  output logic       cnt_en_o
);
  logic mode_counts;

  always_comb begin
    case (xfer_mode_e'(mode_i))
      XM_REPEAT, XM_BLOCK: mode_counts = 1'b1;
      default:             mode_counts = 1'b0;
    endcase
  end

  assign cnt_en_o = stb_i & act_i & mode_counts;
endmodule

// File: rtl/dbs_len_reg.sv
module dbs_len_reg #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             wr_en_i,
  input  logic [LEN_W-1:0] wr_len_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst)
      len_q <= '0;
    else if (wr_en_i && !act_i)
      len_q <= wr_len_i;
  end

  assign len_o = len_q;

  // R5: the length is frozen while the channel runs
  a_r5_len_frozen: assert property (@(posedge clk) disable iff (rst)
    act_i |=> (len_q == $past(len_q)));
endmodule

// File: rtl/dbs_cnt.sv
module dbs_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wr_en_i,
  input  logic [LEN_W-1:0] wr_cnt_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic             end_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q;
  logic             end_q;
  logic             at_one;

  assign at_one = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      end_q <= cnt_en_i & at_one;
      if (cnt_en_i) begin
        if (at_one)
          cnt_q <= len_i;
        else
          cnt_q <= cnt_q - ONE;
      end else if (wr_en_i) begin
        cnt_q <= wr_cnt_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign end_o = end_q;

  // R3: plain decrement above one
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (cnt_en_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE) && !end_q);

  // R4: reload from the length half with a pulse
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (cnt_en_i && cnt_q == ONE) |=> (cnt_q == $past(len_i)) && end_q);

  // R6: zero stands for 65536
  a_r6_zero_wraps: assert property (@(posedge clk) disable iff (rst)
    (cnt_en_i && cnt_q == '0) |=> (cnt_q == '1) && !end_q);

  // R4: the pulse only ever follows a strobe on a count of one
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    end_q |-> $past(cnt_en_i && cnt_q == ONE));
endmodule

// File: rtl/blk_len_counter.sv
module blk_len_counter #(
  parameter int LEN_W = 16,
  localparam int REG_W = 2 * LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       xfer_mode,
  input  logic             chan_act,
  input  logic             xfer_stb,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             blk_end
);
  logic             cnt_en;
  logic [LEN_W-1:0] len_val;
  logic [LEN_W-1:0] cnt_val;

  dbs_step_gate u_gate (
    .mode_i   (xfer_mode),
    .act_i    (chan_act),
    .stb_i    (xfer_stb),
    .cnt_en_o (cnt_en)
  );

  dbs_len_reg #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst      (rst),
    .act_i    (chan_act),
    .wr_en_i  (reg_wr),
    .wr_len_i (reg_wdata[REG_W-1:LEN_W]),
    .len_o    (len_val)
  );

  dbs_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cnt_en_i (cnt_en),
    .len_i    (len_val),
    .wr_en_i  (reg_wr),
    .wr_cnt_i (reg_wdata[LEN_W-1:0]),
    .cnt_o    (cnt_val),
    .end_o    (blk_end)
  );

  assign reg_rdata = {len_val, cnt_val};

  // R7: normal and reserved modes leave the count alone
  a_r7_mode_ignored: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && (xfer_mode == 2'b00 || xfer_mode == 2'b11))
      |=> $stable(reg_rdata[LEN_W-1:0]) && !blk_end);

  // R7: an idle channel leaves the count alone
  a_r7_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !chan_act) |=> $stable(reg_rdata[LEN_W-1:0]) && !blk_end);

  // R10: a write without a counting strobe lands in the count half
  a_r10_cnt_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !(xfer_stb && chan_act && (xfer_mode == 2'b01 || xfer_mode == 2'b10)))
      |=> reg_rdata[LEN_W-1:0] == $past(reg_wdata[LEN_W-1:0]));
endmodule

// File: tb/tb_blk_len_counter.sv
module tb_blk_len_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  xfer_mode;
  logic        chan_act;
  logic        xfer_stb;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        blk_end;

  int n_checks = 0;
  int n_fail   = 0;
  int n_ends   = 0;
  logic [LW-1:0] m_len;
  logic [LW-1:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_len_counter #(.LEN_W(LW)) dut (
    .clk       (clk),
    .rst       (rst),
    .xfer_mode (xfer_mode),
    .chan_act  (chan_act),
    .xfer_stb  (xfer_stb),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .blk_end   (blk_end)
  );

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit counts(input logic [1:0] m, input logic a, input logic s);
    return s && a && (m == 2'b01 || m == 2'b10);
  endfunction

  // drive at negedge, let one posedge pass, compare at the next negedge
  task automatic cyc(input logic w, input logic [31:0] d, input logic [1:0] m,
                     input logic a, input logic s, input string tag);
    logic [LW-1:0] n_len, n_cnt;
    logic          e_end;
    reg_wr = w; reg_wdata = d; xfer_mode = m; chan_act = a; xfer_stb = s;
    n_len = m_len; n_cnt = m_cnt; e_end = 1'b0;
    if (w && !a) n_len = d[31:16];
    if (counts(m, a, s)) begin
      if (m_cnt == 16'd1) begin n_cnt = m_len; e_end = 1'b1; end
      else n_cnt = m_cnt - 16'd1;
    end else if (w) begin
      n_cnt = d[15:0];
    end
    @(negedge clk);
    m_len = n_len; m_cnt = n_cnt;
    if (blk_end) n_ends++;
    chk({blk_end, reg_rdata} === {e_end, n_len, n_cnt}, tag,
        {blk_end, reg_rdata}, {e_end, n_len, n_cnt});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; reg_wr = 0; reg_wdata = '0; xfer_mode = 2'b00; chan_act = 0; xfer_stb = 0;
    m_len = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk({blk_end, reg_rdata} === 33'd0, "R1", {blk_end, reg_rdata}, 33'd0);

    // R2: write and read back while idle
    cyc(1, 32'h0003_0003, 2'b00, 0, 0, "R2");
    // R7: strobes in normal, reserved mode, or with the channel idle
    cyc(0, 0, 2'b00, 1, 1, "R7");
    cyc(0, 0, 2'b11, 1, 1, "R7");
    cyc(0, 0, 2'b01, 0, 1, "R7");
    // R3 and R4: repeat mode 3,2,1,reload
    cyc(0, 0, 2'b01, 1, 1, "R3");
    cyc(0, 0, 2'b01, 1, 1, "R3");
    cyc(0, 0, 2'b01, 1, 1, "R4");
    chk(reg_rdata[15:0] === 16'd3, "R4", {17'd0, reg_rdata[15:0]}, 33'd3);
    cyc(0, 0, 2'b01, 1, 0, "R4");
    // R5 and R10: write while active keeps the length, changes the count
    cyc(1, 32'h0009_0002, 2'b10, 1, 0, "R5");
    chk(reg_rdata === 32'h0003_0002, "R10", {1'b0, reg_rdata}, 33'h0_0003_0002);
    // R8: write and counting strobe together, strobe wins
    cyc(1, 32'h0009_0007, 2'b10, 1, 1, "R8");
    chk(reg_rdata[15:0] === 16'd1, "R8", {17'd0, reg_rdata[15:0]}, 33'd1);
    // R6: zero at a strobe wraps to 65535 with no pulse
    cyc(1, 32'h0000_0000, 2'b10, 1, 0, "R10");
    cyc(0, 0, 2'b10, 1, 1, "R6");
    chk(reg_rdata[15:0] === 16'hFFFF, "R6", {17'd0, reg_rdata[15:0]}, 33'hFFFF);

    // R9: zero length, one full block of 65536 strobes
    cyc(1, 32'h0000_0001, 2'b00, 0, 0, "R9");
    cyc(0, 0, 2'b10, 1, 1, "R9");
    n_ends = 0;
    for (int i = 0; i < 65536; i++) cyc(0, 0, 2'b10, 1, 1, "R9");
    chk(n_ends == 1 && blk_end === 1'b1, "R9", {32'd0, blk_end}, 33'd1);

    // random mix, checked against the bench model (R3, R4, R5, R6, R7, R8, R10)
    for (int i = 0; i < 4000; i++) begin
      logic w, a, s;
      logic [1:0] m;
      logic [31:0] d;
      w = ($urandom % 8) == 0;
      a = ($urandom % 4) != 0;
      s = ($urandom % 2) == 0;
      m = 2'($urandom % 4);
      d = {16'($urandom % 5), 16'($urandom % 5)};
      cyc(w, d, m, a, s, "R3");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule